// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor core and decides, at each instruction boundary, whether the core must divert into a handler and which one. Each source has its own enable bit, and one global enable gates them all. A fixed ranking by vector number picks one winner among the enabled, pending sources. Two kinds of source exist. An event-type source sets a sticky pending bit that stays set until the handler is entered or software clears it. A condition-type source asks for service only while its input is high, and nothing is remembered.

The core reports each completed instruction with a strobe and a two-bit kind code. The controller uses the code to track the global enable: it is cleared on handler entry, set by the enable and return instructions, and cleared by the disable instruction. The controller keeps the rules on which boundary may be interrupted. Once it accepts a request, it stalls the core for the entry sequence and then presents the vector number. A sleeping core can be woken by a request, and the entry then takes longer.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset the global enable, all per-source enables and all pending bits read 0, and take, stall and vector-valid are low.
- R2: Among the enabled pending sources, the lowest source index wins. Source i is reported as vector number i+1, and vector 0 is reserved for reset.
- R3: An accept (take_o high) happens only while the global enable is set, and it clears the global enable from the next cycle on.
- R4: An event-type source that fires while its own enable or the global enable is off stays pending. It is served once both enables are on.
- R5: An event-type pending bit clears when its vector is accepted. It also clears when a 1 is written to its position of the pending register (reg_sel_i=1). Writing 0 leaves the bit as it was.
- R6: A condition-type source (set in LEVEL_MASK) is never latched. If its input drops before it is enabled, no accept follows.
- R7: No accept occurs at the boundary of the enable instruction (kind 1). The global enable is set after it. Wake from sleep is also refused until one more instruction has completed.
- R8: The return instruction (kind 3) sets the global enable, and its own boundary is never taken. A pending request is taken no earlier than the next boundary.
- R9: At the boundary of the disable instruction (kind 2) no accept occurs, even with a request pending in that cycle, and the global enable reads 0 afterwards.
- R10: After an accept from a running core, stall_o stays high and vec_valid_o pulses exactly ENTRY_CYC cycles after the accept cycle (4 by default).
- R11: An accept taken while sleep_i is high (no boundary strobe) delivers the vector ENTRY_CYC+WAKE_CYC cycles after the accept (8 by default).
- R12: Several event-type sources that are pending together are served one accept at a time, in ranking order. A plain instruction (kind 0) boundary that follows a return takes the next one.
- R13: No accept occurs in a cycle without a boundary strobe unless sleep_i is high, so a multi-cycle instruction always completes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | N_SRC | Raw request inputs, one per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0: per-source enable register, 1: pending register (write 1 to clear) |
| reg_wdata_i | input | N_SRC | Register write data |
| reg_rdata_o | output | N_SRC | Read data of the selected register; pending read shows live condition-type inputs |
| insn_done_i | input | 1 | The core completed an instruction this cycle |
| insn_kind_i | input | 2 | Kind of that instruction: 0 plain, 1 enable, 2 disable, 3 return |
| sleep_i | input | 1 | The core is asleep and waits for a wake request |
| take_o | output | 1 | Accept pulse at the boundary where a request is taken |
| stall_o | output | 1 | Core held while the entry sequence runs |
| vec_valid_o | output | 1 | One-cycle pulse: vec_o holds the handler vector |
| vec_o | output | VEC_W | Vector number of the accepted source |
| gie_o | output | 1 | Global enable state |

## Verification
The ranking is driven through a table of enable masks and request patterns. The patterns mix event-type and condition-type inputs, include requests masked by their own enable, and include an all-disabled case, so a wrong encoder, a wrong mask or wrong level handling each shows up as a different vector. Directed sequences then pit request timing against the instruction kinds: a request that arrives while masked, one that vanishes before it is enabled, disable in the same cycle as a pending request, and enable followed by sleep. These separate the boundary gating from the latching. A pair of simultaneous requests handled across a return shows the one-at-a-time order. A wake from sleep shows the longer entry delay.

// File: rtl/irq_ctrl_pkg.sv
// Shared types of the interrupt controller.
// Assumes the core encodes the completed instruction kind in two bits.
package irq_ctrl_pkg;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_SEI   = 2'd1,
        KIND_CLI   = 2'd2,
        KIND_RETI  = 2'd3
    } insn_kind_e;

    typedef enum logic {
        GATE_IDLE  = 1'b0,
        GATE_ENTRY = 1'b1
    } gate_state_e;

endpackage

// File: rtl/irq_src_bank.sv
// Per-source request storage and register bus.
// Event-type sources hold a sticky pending bit. Set wins over a clear in
// the same cycle. Condition-type sources pass the live input.
// Assumes the register bus writes complete in one cycle.
module irq_src_bank #(
    parameter int unsigned          N_SRC      = 6,
    parameter logic [N_SRC-1:0]     LEVEL_MASK = '0,
    localparam int unsigned         SEL_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_i,
    input  logic               reg_we_i,
    input  logic               reg_sel_i,
    input  logic [N_SRC-1:0]   reg_wdata_i,
    input  logic               serve_i,
    input  logic [SEL_W-1:0]   serve_idx_i,
    output logic [N_SRC-1:0]   req_o,
    output logic [N_SRC-1:0]   rdata_o
);

    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] pend_view;

    // Per-source enable register, replaced on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (reg_we_i && !reg_sel_i)
            en_q <= reg_wdata_i;
    end

    // One storage slice per source; the kind of source picks the variant.
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (LEVEL_MASK[i]) begin : g_level
            // Condition-type: no storage at all.
            assign pend_q[i] = 1'b0;
        end else begin : g_event
            logic flag_q;
            logic clr;
            // Clear by service or by a written one.
            assign clr = (serve_i && (serve_idx_i == SEL_W'(i)))
                       || (reg_we_i && reg_sel_i && reg_wdata_i[i]);
            // Sticky flag: a new event dominates any clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q <= 1'b0;
                else
                    flag_q <= (flag_q && !clr) || src_i[i];
            end
            assign pend_q[i] = flag_q;
        end
    end

    // Pending view: stored events plus live conditions.
    assign pend_view = pend_q | (src_i & LEVEL_MASK);

    // Requests that pass their own enable.
    assign req_o = pend_view & en_q;

    // Register read mux.
    assign rdata_o = reg_sel_i ? pend_view : en_q;

endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-ranking selector: the lowest set index wins.
// Assumes requests are already masked by the per-source enables.
module irq_prio_pick #(
    parameter int unsigned  N_SRC = 6,
    localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] req_i,
    output logic             any_o,
    output logic [SEL_W-1:0] idx_o
);

    // Scan from the top so the lowest index is written last.
    always_comb begin
        idx_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i])
                idx_o = SEL_W'(i);
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/irq_gate_ctrl.sv
// Global enable tracking, boundary gating and the entry sequence.
// Assumes insn_done_i pulses once per completed instruction and that
// sleep_i is raised only after the sleep instruction has completed.
module irq_gate_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned  N_SRC     = 6,
    parameter int unsigned  ENTRY_CYC = 4,
    parameter int unsigned  WAKE_CYC  = 4,
    localparam int unsigned SEL_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int unsigned VEC_W     = $clog2(N_SRC + 1),
    localparam int unsigned CNT_W     = $clog2(ENTRY_CYC + WAKE_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done_i,
    input  insn_kind_e       kind_i,
    input  logic             sleep_i,
    input  logic             any_i,
    input  logic [SEL_W-1:0] idx_i,
    output logic             take_o,
    output logic             stall_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             gie_o
);

    gate_state_e      state_q;
    logic             gie_q;
    logic             hold_q;
    logic [CNT_W-1:0] cnt_q;
    logic [VEC_W-1:0] vec_q;
    logic             idle;
    logic             plain_bnd;
    logic             wake_bnd;

    assign idle      = (state_q == GATE_IDLE);
    assign plain_bnd = insn_done_i && (kind_i == KIND_PLAIN);
    assign wake_bnd  = !insn_done_i && sleep_i && !hold_q;

    // Accept decision for this cycle.
    assign take_o = idle && gie_q && any_i && (plain_bnd || wake_bnd);

    // Global enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gie_q <= 1'b0;
        else if (take_o)
            gie_q <= 1'b0;
        else if (idle && insn_done_i) begin
            case (kind_i)
                KIND_SEI, KIND_RETI: gie_q <= 1'b1;
                KIND_CLI:            gie_q <= 1'b0;
                default:             gie_q <= gie_q;
            endcase
        end
    end

    // Holds off a wake until one instruction has followed enable or return.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (idle && insn_done_i)
            hold_q <= (kind_i == KIND_SEI) || (kind_i == KIND_RETI);
    end

    // Entry sequencer: counts the stall and emits the vector at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_IDLE;
            cnt_q   <= '0;
            vec_q   <= '0;
        end else if (take_o) begin
            state_q <= GATE_ENTRY;
            cnt_q   <= wake_bnd ? CNT_W'(ENTRY_CYC + WAKE_CYC - 1)
                                : CNT_W'(ENTRY_CYC - 1);
            vec_q   <= VEC_W'(idx_i) + VEC_W'(1);
        end else if (!idle) begin
            if (cnt_q == '0)
                state_q <= GATE_IDLE;
            else
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign stall_o     = !idle;
    assign vec_valid_o = !idle && (cnt_q == '0);
    assign vec_o       = vec_q;
    assign gie_o       = gie_q;

endmodule

// File: rtl/irq_ctrl_unit.sv
// Top of the interrupt controller: source bank, ranking, gating.
// Assumes one clock domain shared with the core and registers that are
// written only through the local bus.
module irq_ctrl_unit
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned      N_SRC      = 6,
    parameter logic [N_SRC-1:0] LEVEL_MASK = 6'b110000,
    parameter int unsigned      ENTRY_CYC  = 4,
    parameter int unsigned      WAKE_CYC   = 4,
    localparam int unsigned     SEL_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int unsigned     VEC_W      = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             reg_we_i,
    input  logic             reg_sel_i,
    input  logic [N_SRC-1:0] reg_wdata_i,
    output logic [N_SRC-1:0] reg_rdata_o,
    input  logic             insn_done_i,
    input  logic [1:0]       insn_kind_i,
    input  logic             sleep_i,
    output logic             take_o,
    output logic             stall_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             gie_o
);

    logic [N_SRC-1:0] req;
    logic             any_req;
    logic [SEL_W-1:0] win_idx;
    insn_kind_e       kind;

    assign kind = insn_kind_e'(insn_kind_i);

    irq_src_bank #(
        .N_SRC      (N_SRC),
        .LEVEL_MASK (LEVEL_MASK)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .reg_we_i    (reg_we_i),
        .reg_sel_i   (reg_sel_i),
        .reg_wdata_i (reg_wdata_i),
        .serve_i     (take_o),
        .serve_idx_i (win_idx),
        .req_o       (req),
        .rdata_o     (reg_rdata_o)
    );

    irq_prio_pick #(
        .N_SRC (N_SRC)
    ) u_pick (
        .req_i (req),
        .any_o (any_req),
        .idx_o (win_idx)
    );

    irq_gate_ctrl #(
        .N_SRC     (N_SRC),
        .ENTRY_CYC (ENTRY_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_done_i (insn_done_i),
        .kind_i      (kind),
        .sleep_i     (sleep_i),
        .any_i       (any_req),
        .idx_i       (win_idx),
        .take_o      (take_o),
        .stall_o     (stall_o),
        .vec_valid_o (vec_valid_o),
        .vec_o       (vec_o),
        .gie_o       (gie_o)
    );

endmodule

// File: rtl/irq_ctrl_chk.sv
// Protocol checker for the interrupt controller, bound to the top.
module irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       insn_done_i,
    input logic [1:0] insn_kind_i,
    input logic       sleep_i,
    input logic       take_o,
    input logic       stall_o,
    input logic       vec_valid_o,
    input logic       gie_o
);

    // R3
    take_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> gie_o);

    // R3
    take_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !gie_o);

    // R7
    sei_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done_i && insn_kind_i == 2'd1) |-> !take_o);

    // R8
    reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done_i && insn_kind_i == 2'd3 && !stall_o) |=> gie_o);

    // R9
    cli_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done_i && insn_kind_i == 2'd2) |-> !take_o);

    // R13
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_done_i && !sleep_i) |-> !take_o);

    // R10
    entry_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> stall_o);

    // R10
    vec_in_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (stall_o && !take_o));

endmodule

bind irq_ctrl_unit irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_done_i (insn_done_i),
    .insn_kind_i (insn_kind_i),
    .sleep_i     (sleep_i),
    .take_o      (take_o),
    .stall_o     (stall_o),
    .vec_valid_o (vec_valid_o),
    .gie_o       (gie_o)
);

// File: tb/tb_irq_ctrl_unit.sv
module tb_irq_ctrl_unit;

    localparam int N = 6;
    localparam int VW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_i = '0;
    logic          reg_we_i = 1'b0;
    logic          reg_sel_i = 1'b0;
    logic [N-1:0]  reg_wdata_i = '0;
    logic [N-1:0]  reg_rdata_o;
    logic          insn_done_i = 1'b0;
    logic [1:0]    insn_kind_i = 2'd0;
    logic          sleep_i = 1'b0;
    logic          take_o;
    logic          stall_o;
    logic          vec_valid_o;
    logic [VW-1:0] vec_o;
    logic          gie_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_ctrl_unit dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_we_i(reg_we_i),
        .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .insn_done_i(insn_done_i),
        .insn_kind_i(insn_kind_i), .sleep_i(sleep_i), .take_o(take_o),
        .stall_o(stall_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o),
        .gie_o(gie_o)
    );

    // Table rows: {enable mask, held request pattern, expected vector (0 = none)}.
    localparam logic [14:0] VECS [8] = '{
        {6'h3F, 6'b000001, 3'd1},
        {6'h3F, 6'b101000, 3'd4},
        {6'h3E, 6'b000011, 3'd2},
        {6'h30, 6'b110000, 3'd5},
        {6'h20, 6'b110000, 3'd6},
        {6'h00, 6'b111111, 3'd0},
        {6'h3F, 6'b100100, 3'd3},
        {6'h0F, 6'b110000, 3'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [N-1:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
        @(posedge clk); #1;
        reg_we_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd(input logic sel, output logic [N-1:0] d);
        @(negedge clk);
        reg_sel_i = sel;
        #1 d = reg_rdata_o;
    endtask

    task automatic bnd(input logic [1:0] kind, output bit took);
        @(negedge clk);
        insn_done_i = 1'b1; insn_kind_i = kind;
        #1 took = take_o;
        @(posedge clk); #1;
        insn_done_i = 1'b0; insn_kind_i = 2'd0;
    endtask

    task automatic pulse_src(input logic [N-1:0] s);
        @(negedge clk); src_i = s;
        @(negedge clk); src_i = '0;
    endtask

    // Counts cycles from the accept to the vector pulse.
    task automatic wait_vec(input int exp_cyc, input int exp_vec, input string req);
        int got = -1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk); #1;
            if (k == 1) chk(stall_o == 1'b1, "R10 stall", int'(stall_o), 1);
            if (vec_valid_o) begin got = k; break; end
        end
        chk(got == exp_cyc, req, got, exp_cyc);
        chk(int'(vec_o) == exp_vec, req, int'(vec_o), exp_vec);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit took;
        logic [N-1:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        #1;
        chk(gie_o == 0, "R1 gie", int'(gie_o), 0);
        chk(take_o == 0 && stall_o == 0 && vec_valid_o == 0, "R1 outputs",
            int'({take_o, stall_o, vec_valid_o}), 0);
        rd(1'b0, d); chk(d == 0, "R1 enables", int'(d), 0);
        rd(1'b1, d); chk(d == 0, "R1 pending", int'(d), 0);

        // R2: ranking table
        foreach (VECS[r]) begin
            logic [5:0] en  = VECS[r][14:9];
            logic [5:0] pat = VECS[r][8:3];
            int         ev  = int'(VECS[r][2:0]);
            wr(1'b0, en);
            @(negedge clk); src_i = pat;
            @(negedge clk);
            bnd(2'd1, took); chk(!took, "R7 sei boundary", int'(took), 0);
            bnd(2'd0, took);
            chk(took == (ev != 0), "R2 accept", int'(took), int'(ev != 0));
            if (took) wait_vec(4, ev, "R2 vector");
            @(negedge clk); src_i = '0;
            wr(1'b1, '1);
            bnd(2'd2, took);
        end

        // R4 and R5: masked event stays pending, cleared on accept
        wr(1'b0, '0);
        pulse_src(6'b000001);
        rd(1'b1, d); chk(d[0] == 1, "R4 latched", int'(d[0]), 1);
        wr(1'b0, 6'b000001);
        bnd(2'd1, took);
        bnd(2'd0, took); chk(took, "R4 served", int'(took), 1);
        wait_vec(4, 1, "R10 entry length");
        chk(gie_o == 0, "R3 gie cleared", int'(gie_o), 0);
        rd(1'b1, d); chk(d[0] == 0, "R5 cleared by accept", int'(d[0]), 0);

        // R5: write-one-to-clear and write-zero keeps
        pulse_src(6'b000010);
        wr(1'b1, 6'b000000);
        rd(1'b1, d); chk(d[1] == 1, "R5 zero write keeps", int'(d[1]), 1);
        wr(1'b1, 6'b000010);
        rd(1'b1, d); chk(d[1] == 0, "R5 one write clears", int'(d[1]), 0);

        // R6: condition gone before enabling gives nothing
        wr(1'b0, '0);
        pulse_src(6'b010000);
        wr(1'b0, 6'b010000);
        bnd(2'd1, took);
        bnd(2'd0, took); chk(!took, "R6 no latch", int'(took), 0);
        bnd(2'd2, took);

        // R9: disable boundary beats a pending request
        wr(1'b0, 6'b000001);
        bnd(2'd1, took);
        pulse_src(6'b000001);
        bnd(2'd2, took); chk(!took, "R9 cli blocks", int'(took), 0);
        #1 chk(gie_o == 0, "R9 gie off", int'(gie_o), 0);
        bnd(2'd0, took); chk(!took, "R9 stays off", int'(took), 0);

        // R7: wake refused right after enable
        bnd(2'd1, took);
        @(negedge clk); sleep_i = 1'b1;
        #1 chk(!take_o, "R7 wake held", int'(take_o), 0);
        @(negedge clk); sleep_i = 1'b0;
        wr(1'b1, '1);
        bnd(2'd2, took);

        // R11: wake from sleep adds cycles
        bnd(2'd1, took);
        bnd(2'd0, took);
        @(negedge clk); sleep_i = 1'b1; src_i = 6'b000001;
        @(negedge clk); src_i = '0;
        #1 chk(take_o, "R11 wake accept", int'(take_o), 1);
        wait_vec(8, 1, "R11 wake latency");
        @(negedge clk); sleep_i = 1'b0;

        // R12, R13, R8: two pending served in order across a return
        wr(1'b0, 6'b001111);
        pulse_src(6'b000110);
        bnd(2'd1, took);
        @(negedge clk); #1 chk(!take_o, "R13 no boundary", int'(take_o), 0);
        @(negedge clk); #1 chk(!take_o, "R13 still inside", int'(take_o), 0);
        bnd(2'd0, took); chk(took, "R12 first", int'(took), 1);
        wait_vec(4, 2, "R12 first vector");
        bnd(2'd3, took); chk(!took, "R8 return boundary", int'(took), 0);
        #1 chk(gie_o == 1, "R8 gie set", int'(gie_o), 1);
        bnd(2'd0, took); chk(took, "R12 second", int'(took), 1);
        wait_vec(4, 3, "R12 second vector");
        rd(1'b1, d); chk(d == 0, "R12 all served", int'(d), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule